// File: doc/BRIEF.md
# MDIO Target Bridge to a Paged 32-bit Register Space

This block sits on the target side of an MDIO management bus. It gives an MDIO host access to a 32-bit register space that is wider than MDIO allows. The host does this with ordinary 16-bit clause-22 frames. The 5-bit PHY-address field of each frame is reused. Its upper two bits choose an access mode. Its lower three bits, together with the 5-bit register number, carry the low part of a byte address. A page register supplies the upper part of that address. The page is loaded by a dedicated page-set frame and cannot be read back.

Each 32-bit register appears as two 16-bit halves:
- The low half sits at the even half-word (register number bit 0 = 0).
- The high half sits at the next one (register number bit 0 = 1).

Writes follow a fixed order. A write to the high half is only held. The following write to the low half commits all 32 bits to the internal bus in a single access. This ordering exists because some registers carry trigger bits in their low half.

Reads work in the other direction. A read of the low half fetches the whole word and keeps it. A read of the high half that follows it is then served from that same word. Frames whose mode field selects bypass are left entirely to a real PHY on the same wires.

The bridge masters a simple request/acknowledge register bus. The bus must answer within one MDC period.

Top module: `mdio_bridge`

## Requirements
- R1: While reset is asserted, and right after it, the block does not drive MDIO (`mdioOe` = 0) and issues no bus request (`busReq` = 0).
- R2: A write frame (op = 01) whose PHY-address bits 4:3 equal 3 (page mode) stores data bits 9:0 as the page. The page supplies bus address bits 18:9 of every later register access. A read frame (op = 10) in page mode is not answered, so the line reads all ones, and it causes no bus access.
- R3: In register mode (PHY-address bits 4:3 = 2), the bus byte address is built from three parts. The page forms bits 18:9. PHY-address bits 2:0 form bits 8:6. Register number bits 4:1 form bits 5:2. Bits 1:0 are zero.
- R4: A register-mode write with register number bit 0 = 1 (high half) is held and causes no bus access.
- R5: A register-mode write with register number bit 0 = 0 (low half) makes exactly one bus write. Its 32-bit data is the last held high half in bits 31:16 and the frame data in bits 15:0.
- R6: A register-mode read of a low half makes one bus read of the word. It returns word bits 15:0 in the data phase, most significant bit first.
- R7: A register-mode read of a high half returns bits 31:16 of the word last fetched by a low-half read, and makes no new bus access, when three conditions hold: that fetch was of the same word, it was the most recent bus access, and no write has been committed since.
- R8: A register-mode read of a high half makes a fresh bus read, and returns bits 31:16 of that result, in two cases. The first is when no matching fetched word is held. The second is when a low-half write has been committed since the fetch.
- R9: Frames with PHY-address bit 4 = 0 (bypass, and the unused mode 1) are ignored. They cause no MDIO drive and no bus access, and they leave the page and the held high half unchanged.
- R10: On an answered read, MDIO is released during the first turnaround bit. It is driven 0 during the second turnaround bit, held through the 16 data bits, and released after the last one.
- R11: Reset clears the page, so register accesses after reset use page 0.
- R12: A bus request stays asserted, with address, direction and write data stable, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, sampling MDC and MDIO |
| rstN | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | MDIO management clock from the host |
| mdioIn | input | 1 | Resolved level of the MDIO line |
| mdioOut | output | 1 | Value this block drives onto MDIO |
| mdioOe | output | 1 | Output enable for `mdioOut` |
| busReq | output | 1 | Internal bus request, held until acknowledged |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | 19 | Byte address of the 32-bit word |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | One-cycle acknowledge from the register space |
| busRdata | input | 32 | Read data, valid with `busAck` |

## Verification
The hardest state to reach is the one where the high-half read must be served from a stale-but-correct word rather than from the bus. The bench reaches it by fetching a low half and then changing the data the bus model would return before issuing the high-half read. Any access that wrongly went back to the bus would show up both in the read count and in the returned value. The invalidating path is reached in two ways. One places a committed low-half write between the two reads. The other reads a high half for a word that was never fetched. Bypass and page-mode frames are followed by a normal committed write, which exposes through the bus address and data whether the page or the held high half was disturbed.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  // Mode field carried in PHY-address bits 4:3
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_RSVD   = 2'd1,
    MODE_REG    = 2'd2,
    MODE_PAGE   = 2'd3
  } accMode_e;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // Control-to-datapath strobes; field values are held from the header on
  typedef struct packed {
    logic        hdrValid;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regNum;
    logic        txLoad;
    logic        txShift;
    logic        txRelease;
    logic        wrValid;
    logic [15:0] wrData;
  } ctrlStrobe_t;

endpackage

// File: rtl/mdio_bridge_sync.sv
module mdio_bridge_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= RESET_VAL;
        else       pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= RESET_VAL;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mdcS,
  input  logic        mdioS,
  output ctrlStrobe_t stb
);

  localparam int HDR_BITS  = 12;
  localparam int DATA_BITS = 16;
  localparam int CNT_W     = $clog2(DATA_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_HDR, S_TA, S_DATA} frameState_e;

  frameState_e          state;
  logic [CNT_W-1:0]     bitCnt;
  logic [HDR_BITS-2:0]  hdrSh;
  logic [DATA_BITS-2:0] dataSh;
  logic [HDR_BITS-1:0]  hdrFull;
  logic                 mdcQ;
  logic                 mdcRise;
  logic                 answer;
  logic [1:0]           opQ;
  logic [4:0]           phyQ;
  logic [4:0]           regQ;
  logic [15:0]          wrDataQ;
  logic                 hdrP, loadP, shiftP, relP, wrP;

  assign mdcRise = mdcS & ~mdcQ;
  assign hdrFull = {hdrSh, mdioS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      hdrSh   <= '0;
      dataSh  <= '0;
      mdcQ    <= 1'b0;
      answer  <= 1'b0;
      opQ     <= '0;
      phyQ    <= '0;
      regQ    <= '0;
      wrDataQ <= '0;
      hdrP    <= 1'b0;
      loadP   <= 1'b0;
      shiftP  <= 1'b0;
      relP    <= 1'b0;
      wrP     <= 1'b0;
    end else begin
      mdcQ   <= mdcS;
      hdrP   <= 1'b0;
      loadP  <= 1'b0;
      shiftP <= 1'b0;
      relP   <= 1'b0;
      wrP    <= 1'b0;
      if (mdcRise) begin
        case (state)
          S_IDLE: begin
            if (!mdioS) state <= S_START;
          end
          S_START: begin
            bitCnt <= '0;
            state  <= mdioS ? S_HDR : S_IDLE;
          end
          S_HDR: begin
            hdrSh  <= hdrFull[HDR_BITS-2:0];
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == CNT_W'(HDR_BITS - 1)) begin
              opQ    <= hdrFull[11:10];
              phyQ   <= hdrFull[9:5];
              regQ   <= hdrFull[4:0];
              answer <= (hdrFull[11:10] == OP_READ) &&
                        (accMode_e'(hdrFull[9:8]) == MODE_REG);
              hdrP   <= 1'b1;
              bitCnt <= '0;
              state  <= S_TA;
            end
          end
          S_TA: begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == '0) begin
              loadP <= answer;
            end else begin
              shiftP <= answer;
              bitCnt <= '0;
              state  <= S_DATA;
            end
          end
          S_DATA: begin
            dataSh <= {dataSh[DATA_BITS-3:0], mdioS};
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == CNT_W'(DATA_BITS - 1)) begin
              relP  <= answer;
              state <= S_IDLE;
              if (opQ == OP_WRITE) begin
                wrP     <= 1'b1;
                wrDataQ <= {dataSh, mdioS};
              end
            end else begin
              shiftP <= answer;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb.hdrValid  = hdrP;
    stb.op        = opQ;
    stb.phy       = phyQ;
    stb.regNum    = regQ;
    stb.txLoad    = loadP;
    stb.txShift   = shiftP;
    stb.txRelease = relP;
    stb.wrValid   = wrP;
    stb.wrData    = wrDataQ;
  end

endmodule

// File: rtl/mdio_bridge_dpath.sv
module mdio_bridge_dpath
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  output logic              busReq,
  output logic              busWe,
  output logic [PAGE_W+8:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic [31:0]       busRdata,
  output logic              mdioOut,
  output logic              mdioOe
);

  localparam int IDX_W  = PAGE_W + 7;
  localparam int ADDR_W = PAGE_W + 9;

  logic [PAGE_W-1:0] pageQ;
  logic [15:0]       hiHold;
  accMode_e          curMode;
  logic              curHalf;
  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  newIdx;
  logic [IDX_W-1:0]  busIdx;
  logic [31:0]       rdWord;
  logic [IDX_W-1:0]  rdIdx;
  logic              rdValid;
  logic [16:0]       txReg;
  logic              fetchNeeded;

  assign newIdx  = {pageQ, stb.phy[2:0], stb.regNum[4:1]};
  assign busIdx  = busAddr[ADDR_W-1:2];
  assign mdioOut = txReg[16];

  // Low half always refetches; high half only when no matching word is held
  assign fetchNeeded = (stb.op == OP_READ) &&
                       (accMode_e'(stb.phy[4:3]) == MODE_REG) &&
                       (!stb.regNum[0] || !rdValid || (rdIdx != newIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ    <= '0;
      hiHold   <= '0;
      curMode  <= MODE_BYPASS;
      curHalf  <= 1'b0;
      curIdx   <= '0;
      rdWord   <= '0;
      rdIdx    <= '0;
      rdValid  <= 1'b0;
      busReq   <= 1'b0;
      busWe    <= 1'b0;
      busAddr  <= '0;
      busWdata <= '0;
      txReg    <= '1;
      mdioOe   <= 1'b0;
    end else begin
      if (busReq && busAck) begin
        busReq <= 1'b0;
        if (!busWe) begin
          rdWord  <= busRdata;
          rdIdx   <= busIdx;
          rdValid <= 1'b1;
        end
      end

      if (stb.hdrValid) begin
        curMode <= accMode_e'(stb.phy[4:3]);
        curHalf <= stb.regNum[0];
        curIdx  <= newIdx;
        if (fetchNeeded) begin
          busReq  <= 1'b1;
          busWe   <= 1'b0;
          busAddr <= {newIdx, 2'b00};
        end
      end

      if (stb.wrValid) begin
        case (curMode)
          MODE_PAGE: pageQ <= stb.wrData[PAGE_W-1:0];
          MODE_REG: begin
            if (curHalf) begin
              hiHold <= stb.wrData;
            end else begin
              busReq   <= 1'b1;
              busWe    <= 1'b1;
              busAddr  <= {curIdx, 2'b00};
              busWdata <= {hiHold, stb.wrData};
              rdValid  <= 1'b0;
            end
          end
          default: ;
        endcase
      end

      if (stb.txLoad) begin
        txReg  <= {1'b0, curHalf ? rdWord[31:16] : rdWord[15:0]};
        mdioOe <= 1'b1;
      end else if (stb.txShift) begin
        txReg <= {txReg[15:0], 1'b1};
      end
      if (stb.txRelease) mdioOe <= 1'b0;
    end
  end

endmodule

// File: rtl/mdio_bridge.sv
module mdio_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdc,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              busReq,
  output logic              busWe,
  output logic [PAGE_W+8:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic [31:0]       busRdata
);

  logic [1:0]  syncQ;
  ctrlStrobe_t stb;

  mdio_bridge_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH(2),
    .RESET_VAL(2'b01)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({mdc, mdioIn}),
    .q   (syncQ)
  );

  mdio_bridge_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .mdcS (syncQ[1]),
    .mdioS(syncQ[0]),
    .stb  (stb)
  );

  mdio_bridge_dpath #(.PAGE_W(PAGE_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busReq  (busReq),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busAck  (busAck),
    .busRdata(busRdata),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe)
  );

endmodule

// File: rtl/mdio_bridge_checker.sv
module mdio_bridge_checker
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input ctrlStrobe_t       stb,
  input logic              busReq,
  input logic              busAck,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              mdioOe
);

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (!busReq && !mdioOe);
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata));

  assert_drive_after_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> $past(stb.txLoad));

  assert_hi_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrValid && (stb.phy[4:3] == 2'b10) && stb.regNum[0] |=> !busReq);

  assert_lo_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrValid && (stb.phy[4:3] == 2'b10) && !stb.regNum[0]
      |=> busReq && busWe && (busWdata[15:0] == $past(stb.wrData)));

  assert_bypass_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.hdrValid && !stb.phy[4] |=> !busReq && !mdioOe);

endmodule

bind mdio_bridge mdio_bridge_checker #(.ADDR_W(PAGE_W + 9)) u_check (
  .clk     (clk),
  .rstN    (rstN),
  .stb     (stb),
  .busReq  (busReq),
  .busAck  (busAck),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .mdioOe  (mdioOe)
);

// File: tb/mdio_bridge_bench.sv
module mdio_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MDC_HALF   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mdc = 1'b0;
  logic        masterDrive = 1'b1;
  logic        masterBit = 1'b1;
  logic        mdioIn;
  logic        mdioOut, mdioOe;
  logic        busReq, busWe, busAck;
  logic [18:0] busAddr;
  logic [31:0] busWdata, busRdata;

  logic [31:0] salt = 32'h0;
  int          nReads = 0, nWrites = 0;
  logic [18:0] lastAddr = '0;
  logic [31:0] lastWdata = '0;
  int          nChk = 0, nBad = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mdioIn = mdioOe ? mdioOut : (masterDrive ? masterBit : 1'b1);

  mdio_bridge u_mdio_bridge (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata)
  );

  function automatic logic [31:0] wordAt(input logic [18:0] a);
    return salt ^ {13'h0, a};
  endfunction

  // Register-space model: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rstN) begin
      busAck   <= 1'b0;
      busRdata <= '0;
    end else if (busReq && !busAck) begin
      busAck   <= 1'b1;
      lastAddr <= busAddr;
      if (busWe) begin
        nWrites   <= nWrites + 1;
        lastWdata <= busWdata;
      end else begin
        nReads   <= nReads + 1;
        busRdata <= wordAt(busAddr);
      end
    end else begin
      busAck <= 1'b0;
    end
  end

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdcBit(input logic drv, input logic b, output logic seen);
    masterDrive = drv;
    masterBit   = b;
    mdc         = 1'b0;
    repeat (MDC_HALF) @(negedge clk);
    seen = mdioIn;
    mdc  = 1'b1;
    repeat (MDC_HALF) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rn,
                       input logic [15:0] wd, output logic [15:0] rd,
                       output logic ta1, output logic ta2);
    logic s;
    logic [13:0] hdrBits;
    hdrBits = {2'b01, op, phy, rn};
    for (int i = 0; i < 32; i++) mdcBit(1'b1, 1'b1, s);
    for (int i = 13; i >= 0; i--) mdcBit(1'b1, hdrBits[i], s);
    if (op == 2'b10) begin
      mdcBit(1'b0, 1'b1, ta1);
      mdcBit(1'b0, 1'b1, ta2);
      for (int i = 15; i >= 0; i--) begin
        mdcBit(1'b0, 1'b1, s);
        rd[i] = s;
      end
    end else begin
      mdcBit(1'b1, 1'b1, ta1);
      mdcBit(1'b1, 1'b0, ta2);
      for (int i = 15; i >= 0; i--) mdcBit(1'b1, wd[i], s);
      rd = wd;
    end
    mdcBit(1'b0, 1'b1, s);
  endtask

  task automatic wrFrame(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] wd);
    logic [15:0] d;
    logic t1, t2;
    frame(2'b01, phy, rn, wd, d, t1, t2);
  endtask

  task automatic rdFrame(input logic [4:0] phy, input logic [4:0] rn,
                         output logic [15:0] d, output logic t1, output logic t2);
    frame(2'b10, phy, rn, 16'h0, d, t1, t2);
  endtask

  typedef struct packed {
    logic [9:0]  page;
    logic [2:0]  phy;
    logic [4:0]  rn;
    logic [15:0] hi;
    logic [15:0] lo;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{page: 10'h000, phy: 3'd0, rn: 5'd0,  hi: 16'hDEAD, lo: 16'hBEEF},
    '{page: 10'h3FF, phy: 3'd7, rn: 5'd30, hi: 16'h1234, lo: 16'h5678},
    '{page: 10'h155, phy: 3'd2, rn: 5'd10, hi: 16'h0000, lo: 16'hFFFF},
    '{page: 10'h2AA, phy: 3'd5, rn: 5'd20, hi: 16'hA5A5, lo: 16'h0001}
  };

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL R12 watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic t1, t2;
    logic [18:0] a;
    logic [31:0] w;
    int r0, w0;

    repeat (5) @(negedge clk);
    chkEq("R1 oe in reset", {31'h0, mdioOe}, 32'h0);
    chkEq("R1 req in reset", {31'h0, busReq}, 32'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chkEq("R1 oe after reset", {31'h0, mdioOe}, 32'h0);
    chkEq("R1 req after reset", {31'h0, busReq}, 32'h0);

    // Table walk: write pair, read pair with changed bus data in between
    for (int i = 0; i < 4; i++) begin
      a = {VEC[i].page, VEC[i].phy, VEC[i].rn, 1'b0};
      wrFrame(5'b11000, 5'd0, {6'h0, VEC[i].page});
      w0 = nWrites;
      wrFrame({2'b10, VEC[i].phy}, VEC[i].rn | 5'd1, VEC[i].hi);
      chkEq("R4 high half held", nWrites, w0);
      wrFrame({2'b10, VEC[i].phy}, VEC[i].rn, VEC[i].lo);
      chkEq("R5 one commit", nWrites, w0 + 1);
      chkEq("R5 commit data", lastWdata, {VEC[i].hi, VEC[i].lo});
      chkEq("R3 write address", {13'h0, lastAddr}, {13'h0, a});
      salt = {VEC[i].hi, VEC[i].lo} ^ 32'h0F0F_3C3C;
      w = wordAt(a);
      r0 = nReads;
      rdFrame({2'b10, VEC[i].phy}, VEC[i].rn, d, t1, t2);
      chkEq("R6 low half data", {16'h0, d}, {16'h0, w[15:0]});
      chkEq("R6 one fetch", nReads, r0 + 1);
      chkEq("R3 read address", {13'h0, lastAddr}, {13'h0, a});
      chkEq("R10 turnaround", {30'h0, t1, t2}, 32'h2);
      chkEq("R10 released", {31'h0, mdioOe}, 32'h0);
      salt = ~salt;
      rdFrame({2'b10, VEC[i].phy}, VEC[i].rn | 5'd1, d, t1, t2);
      chkEq("R7 high half from held word", {16'h0, d}, {16'h0, w[31:16]});
      chkEq("R7 no new fetch", nReads, r0 + 1);
    end

    // R2: page-mode read not answered, page used by next access
    wrFrame(5'b11000, 5'd0, 16'h03C3);
    r0 = nReads;
    rdFrame(5'b11000, 5'd0, d, t1, t2);
    chkEq("R2 page read undriven", {15'h0, t2, d}, {15'h0, 1'b1, 16'hFFFF});
    chkEq("R2 page read no bus", nReads, r0);
    wrFrame(5'b10001, 5'd5, 16'hCAFE);
    wrFrame(5'b10001, 5'd4, 16'h4444);
    chkEq("R2 page in address", {13'h0, lastAddr}, {13'h0, 10'h3C3, 3'd1, 5'd4, 1'b0});

    // R9: bypass and mode 1 frames touch nothing
    w0 = nWrites;
    r0 = nReads;
    wrFrame(5'b00011, 5'd7, 16'h9999);
    wrFrame(5'b01001, 5'd0, 16'h0011);
    wrFrame(5'b00010, 5'd2, 16'h5555);
    rdFrame(5'b00001, 5'd2, d, t1, t2);
    chkEq("R9 bypass read undriven", {15'h0, t2, d}, {15'h0, 1'b1, 16'hFFFF});
    chkEq("R9 no bus writes", nWrites, w0);
    chkEq("R9 no bus reads", nReads, r0);
    wrFrame(5'b10001, 5'd6, 16'h7777);
    chkEq("R9 held high half kept", lastWdata, 32'hCAFE_7777);
    chkEq("R9 page kept", {13'h0, lastAddr}, {13'h0, 10'h3C3, 3'd1, 5'd6, 1'b0});

    // R8: high half with nothing fetched
    salt = 32'h1357_9BDF;
    a = {10'h3C3, 3'd2, 5'd12, 1'b0};
    r0 = nReads;
    rdFrame(5'b10010, 5'd13, d, t1, t2);
    w = wordAt(a);
    chkEq("R8 cold high fetch", nReads, r0 + 1);
    chkEq("R8 cold high data", {16'h0, d}, {16'h0, w[31:16]});
    // R8: fetch, commit write, then high half must refetch
    rdFrame(5'b10010, 5'd12, d, t1, t2);
    wrFrame(5'b10010, 5'd12, 16'h0BAD);
    salt = 32'h2468_ACE0;
    w = wordAt(a);
    r0 = nReads;
    rdFrame(5'b10010, 5'd13, d, t1, t2);
    chkEq("R8 refetch after write", nReads, r0 + 1);
    chkEq("R8 refetch data", {16'h0, d}, {16'h0, w[31:16]});

    // R11: reset clears the page
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R1 oe in second reset", {31'h0, mdioOe}, 32'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    wrFrame(5'b10011, 5'd8, 16'h0042);
    chkEq("R11 page cleared", {13'h0, lastAddr}, {13'h0, 10'h000, 3'd3, 5'd8, 1'b0});

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule